// File: doc/BRIEF.md
# Peripheral Command Block Parser

This block walks a 64-byte command memory and carries out the peripheral transactions encoded in it, one channel after another. Software fills the memory with a sequence of length-prefixed frames and puts a start code into its last byte, then pulses `start`. The parser reads each frame, passes its command to a small fixed responder for the channel the frame occupies, and writes the reply bytes, or a failure flag, back into the same memory in place. When the walk ends it clears the last byte and pulses `done` for one cycle.

The memory sits outside the block. It is reached through a byte-wide port with a combinational read and a write that takes effect on the clock edge. The parser handles one memory byte per clock. There is no serial line timing here. The replies come from internal stubs: a status reply on two channels and a 32-bit controller-input word on channel 0.

Top module: `cmd_block_parser`

## Requirements
- R1: A walk starts only on a `start` pulse while byte 0x3F holds 0x01. With any other value there, `done` pulses two cycles after `start` and no byte of the memory is written.
- R2: The walk reads length bytes from address 0 upward and stops when the pointer reaches 0x3F. A length byte of 0xFE stops it at once.
- R3: A length byte that is zero, or whose bit 7 or bit 6 is set (apart from 0xFE), is skipped. The walk continues with the next byte.
- R4: Channel numbers start at 0 and count up by one for every length byte read that does not stop the walk, skipped ones included. A frame takes the channel number of its own length byte.
- R5: A valid frame is laid out as: transmit length T, receive length R, T transmit bytes (the first of them is the command code), then R receive bytes. On success the reply fills the receive bytes and the walk resumes after them. An R of 0xFE stops the walk.
- R6: On a failed command no receive byte is written. Bit 7 of the frame's receive-length byte is set, and the walk resumes right after the transmit bytes.
- R7: Command 0x00 or 0xFF replies 05 00 01 on channel 0 and 00 80 00 on channel 4. On every other channel it fails.
- R8: Command 0x01 replies with `pad_word` on channel 0, most significant byte first, and fails on every other channel. Every other command code fails.
- R9: Receive bytes beyond the reply length are written as 0x00. A receive length shorter than the reply keeps only the leading reply bytes.
- R10: The walk never reads a frame byte from 0x3F and never writes a reply to 0x3F: a frame that needs a byte at 0x3F ends the walk, and reply bytes that would land at 0x3F or beyond are dropped.
- R11: At the end of a started walk, byte 0x3F is written with 0x00, and `done` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to process the memory |
| pad_word | input | 32 | Controller-input word returned by command 0x01 |
| ram_rdata | input | 8 | Combinational read data at `ram_addr` |
| ram_addr | output | 6 | Memory byte address |
| ram_we | output | 1 | Write enable for `ram_wdata` at `ram_addr` |
| ram_wdata | output | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The last reply write of a frame and the saturation of the pointer at 0x3F fall in the same cycle. In that cycle the parser stops the reply at 0x3E and moves on to the closing write of 0x3F. This is provoked by a channel-0 status frame with transmit length 0x37 and receive length 8, whose receive area starts at 0x39 and would run past the end. It is judged by comparing the whole memory after `done`: 0x39 to 0x3E hold 05 00 01 00 00 00, 0x3F holds 0x00, and `done` is high for a single cycle.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    localparam logic [7:0] START_CODE  = 8'h01;
    localparam logic [7:0] END_MARK    = 8'hFE;
    localparam logic [7:0] FAIL_FLAG   = 8'h80;
    localparam logic [7:0] CMD_STATUS  = 8'h00;
    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_BUTTONS = 8'h01;

    localparam int PAD_CHAN = 0;
    localparam int AUX_CHAN = 4;

    localparam logic [23:0] PAD_STATUS = 24'h050001;
    localparam logic [23:0] AUX_STATUS = 24'h008000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_LEN, ST_RXLEN, ST_CMD, ST_RESP, ST_FIN, ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [7:0] tx_len;
        logic [7:0] rx_len;
        logic [7:0] code;
    } frame_t;

    function automatic logic len_opens_frame(input logic [7:0] b);
        return (b != 8'h00) && (b[7:6] == 2'b00);
    endfunction

endpackage

// File: rtl/cbp_responder.sv
module cbp_responder
    import cbp_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int PAD_W = 32
) (
    input  logic [7:0]       code,
    input  logic [CH_W-1:0]  chan,
    input  logic [7:0]       idx,
    input  logic [PAD_W-1:0] pad,
    output logic             fail,
    output logic [7:0]       data
);
    localparam int WORD_W = (PAD_W > 24) ? PAD_W : 24;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shifted;
    logic [7:0]        len;
    logic              is_status;

    always_comb begin
        is_status = (code == CMD_STATUS) || (code == CMD_RESET);
        word      = '0;
        len       = 8'd0;
        fail      = 1'b1;
        if (is_status && chan == CH_W'(PAD_CHAN)) begin
            word = {PAD_STATUS, {(WORD_W-24){1'b0}}};
            len  = 8'd3;
            fail = 1'b0;
        end else if (is_status && chan == CH_W'(AUX_CHAN)) begin
            word = {AUX_STATUS, {(WORD_W-24){1'b0}}};
            len  = 8'd3;
            fail = 1'b0;
        end else if (code == CMD_BUTTONS && chan == CH_W'(PAD_CHAN)) begin
            word = {pad, {(WORD_W-PAD_W){1'b0}}};
            len  = 8'(PAD_W / 8);
            fail = 1'b0;
        end
        shifted = word << (8 * 32'(idx));
        data    = (idx < len) ? shifted[WORD_W-1 -: 8] : 8'h00;
    end

endmodule

// File: rtl/cbp_walker.sv
module cbp_walker
    import cbp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic              done,
    input  logic              rsp_fail,
    input  logic [7:0]        rsp_byte,
    output logic [7:0]        rsp_code,
    output logic [CH_W-1:0]   rsp_chan,
    output logic [7:0]        rsp_idx,
    output walk_state_e       st
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << ADDR_W) - 1);
    localparam int SUM_W = ((ADDR_W > 8) ? ADDR_W : 8) + 1;

    function automatic logic [ADDR_W-1:0] clip(input logic [SUM_W-1:0] s);
        return (s >= SUM_W'(LAST)) ? LAST : s[ADDR_W-1:0];
    endfunction

    walk_state_e       st_q;
    frame_t            frm_q;
    logic [ADDR_W-1:0] ptr_q, rx_at_q, base_q;
    logic [CH_W-1:0]   chan_q, frm_chan_q;
    logic [7:0]        idx_q;
    logic [SUM_W-1:0]  wr_sum;
    logic              at_end, rsp_over;

    assign at_end   = (ptr_q == LAST);
    assign wr_sum   = SUM_W'(base_q) + SUM_W'(idx_q);
    assign rsp_over = (idx_q == frm_q.rx_len) || (wr_sum >= SUM_W'(LAST));
    assign rsp_code = frm_q.code;
    assign rsp_chan = frm_chan_q;
    assign rsp_idx  = idx_q;
    assign st       = st_q;
    assign done     = (st_q == ST_DONE);

    always_comb begin
        ram_addr  = ptr_q;
        ram_we    = 1'b0;
        ram_wdata = 8'h00;
        case (st_q)
            ST_CHECK: ram_addr = LAST;
            ST_RESP: begin
                if (rsp_fail) begin
                    ram_addr  = rx_at_q;
                    ram_we    = 1'b1;
                    ram_wdata = frm_q.rx_len | FAIL_FLAG;
                end else if (!rsp_over) begin
                    ram_addr  = wr_sum[ADDR_W-1:0];
                    ram_we    = 1'b1;
                    ram_wdata = rsp_byte;
                end
            end
            ST_FIN: begin
                ram_addr = LAST;
                ram_we   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            frm_q      <= '0;
            ptr_q      <= '0;
            rx_at_q    <= '0;
            base_q     <= '0;
            chan_q     <= '0;
            frm_chan_q <= '0;
            idx_q      <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_CHECK;
                ST_CHECK: begin
                    ptr_q  <= '0;
                    chan_q <= '0;
                    st_q   <= (ram_rdata == START_CODE) ? ST_LEN : ST_DONE;
                end
                ST_LEN: begin
                    if (at_end) begin
                        st_q <= ST_FIN;
                    end else begin
                        ptr_q <= ptr_q + ADDR_W'(1);
                        if (ram_rdata == END_MARK) begin
                            st_q <= ST_FIN;
                        end else begin
                            frm_chan_q   <= chan_q;
                            chan_q       <= chan_q + CH_W'(1);
                            frm_q.tx_len <= ram_rdata;
                            if (len_opens_frame(ram_rdata)) st_q <= ST_RXLEN;
                        end
                    end
                end
                ST_RXLEN: begin
                    if (at_end) begin
                        st_q <= ST_FIN;
                    end else begin
                        frm_q.rx_len <= ram_rdata;
                        rx_at_q      <= ptr_q;
                        ptr_q        <= ptr_q + ADDR_W'(1);
                        st_q         <= (ram_rdata == END_MARK) ? ST_FIN : ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (at_end) begin
                        st_q <= ST_FIN;
                    end else begin
                        frm_q.code <= ram_rdata;
                        base_q     <= clip(SUM_W'(ptr_q) + SUM_W'(frm_q.tx_len));
                        idx_q      <= 8'd0;
                        st_q       <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_fail) begin
                        ptr_q <= base_q;
                        st_q  <= ST_LEN;
                    end else if (rsp_over) begin
                        ptr_q <= clip(SUM_W'(base_q) + SUM_W'(frm_q.rx_len));
                        st_q  <= ST_LEN;
                    end else begin
                        idx_q <= idx_q + 8'd1;
                    end
                end
                ST_FIN:  st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmd_block_parser.sv
module cmd_block_parser
    import cbp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CH_W   = 8,
    parameter int PAD_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAD_W-1:0]  pad_word,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic              done
);
    logic            rsp_fail_w;
    logic [7:0]      rsp_byte_w, rsp_code_w, rsp_idx_w;
    logic [CH_W-1:0] rsp_chan_w;
    walk_state_e     st_w;

    cbp_walker #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_walk (
        .clk(clk), .rst(rst), .start(start),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .done(done),
        .rsp_fail(rsp_fail_w), .rsp_byte(rsp_byte_w),
        .rsp_code(rsp_code_w), .rsp_chan(rsp_chan_w),
        .rsp_idx(rsp_idx_w), .st(st_w)
    );

    cbp_responder #(.CH_W(CH_W), .PAD_W(PAD_W)) u_rsp (
        .code(rsp_code_w), .chan(rsp_chan_w), .idx(rsp_idx_w),
        .pad(pad_word), .fail(rsp_fail_w), .data(rsp_byte_w)
    );

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker
    import cbp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_wdata,
    input logic [7:0]        ram_rdata,
    input walk_state_e       st,
    input logic              rsp_fail
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << ADDR_W) - 1);

    p_no_code_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK && ram_rdata != START_CODE) |=> (done && !ram_we));

    p_fail_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RESP && rsp_fail) |-> (ram_we && ram_wdata[7]));

    p_reply_clip_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RESP && ram_we) |-> (ram_addr != LAST));

    p_last_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == LAST) |-> (ram_wdata == 8'h00));

    p_clear_then_done_r11: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == LAST) |=> done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !ram_we));

endmodule

bind cmd_block_parser cbp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .done(done), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .st(st_w), .rsp_fail(rsp_fail_w)
);

// File: tb/cmd_block_parser_tb.sv
`timescale 1ns/1ps
module cmd_block_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] pad_word = 32'hA1B2C3D4;
    logic [7:0]  ram_rdata;
    logic [5:0]  ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic        done;

    logic [7:0] mem [64];
    logic [7:0] ref_m [64];
    logic [7:0] exp_q [$];
    int    n_run = 0;
    int    n_fail = 0;
    int    done_seen = 0;
    string cur_tag = "";
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    cmd_block_parser dut_i (
        .clk(clk), .rst(rst), .start(start), .pad_word(pad_word),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .done(done)
    );

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference walk written from the requirements (R2..R10), then R11 clear.
    task automatic model_run();
        int p, ch, c, base;
        logic [7:0] t, r, cmd;
        logic [7:0] rb [4];
        int rlen;
        bit fl;
        int ra;
        if (ref_m[63] != 8'h01) return;     // R1
        p = 0; ch = 0;
        while (1) begin
            if (p >= 63) break;
            t = ref_m[p]; p++;
            if (t == 8'hFE) break;
            c = ch; ch++;                    // R4
            if (t == 8'h00 || t[7:6] != 2'b00) continue;   // R3
            if (p >= 63) break;              // R10
            r = ref_m[p]; ra = p; p++;
            if (r == 8'hFE) break;           // R5
            if (p >= 63) break;
            cmd = ref_m[p];
            base = (p + t > 63) ? 63 : p + t;
            fl = 1'b0; rlen = 0;
            rb[0] = 0; rb[1] = 0; rb[2] = 0; rb[3] = 0;
            if ((cmd == 8'h00 || cmd == 8'hFF) && c == 0) begin
                rb[0] = 8'h05; rb[1] = 8'h00; rb[2] = 8'h01; rlen = 3;   // R7
            end else if ((cmd == 8'h00 || cmd == 8'hFF) && c == 4) begin
                rb[0] = 8'h00; rb[1] = 8'h80; rb[2] = 8'h00; rlen = 3;
            end else if (cmd == 8'h01 && c == 0) begin                   // R8
                rb[0] = pad_word[31:24]; rb[1] = pad_word[23:16];
                rb[2] = pad_word[15:8];  rb[3] = pad_word[7:0]; rlen = 4;
            end else fl = 1'b1;
            if (fl) begin
                ref_m[ra] = r | 8'h80;       // R6
                p = base;
            end else begin
                for (int i = 0; i < int'(r); i++)
                    if (base + i < 63) ref_m[base + i] = (i < rlen) ? rb[i] : 8'h00;  // R9
                p = (base + int'(r) > 63) ? 63 : base + int'(r);
            end
        end
        ref_m[63] = 8'h00;                   // R11
    endtask

    task automatic clear_mem(input logic [7:0] v);
        for (int i = 0; i < 64; i++) mem[i] = v;
    endtask

    // Driver: computes the expected image, queues it, starts the block.
    task automatic run_case(input string tag);
        int waitc;
        for (int i = 0; i < 64; i++) ref_m[i] = mem[i];
        model_run();
        for (int i = 0; i < 64; i++) exp_q.push_back(ref_m[i]);
        cur_tag = tag;
        done_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        waitc = 0;
        while (done_seen == 0 && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        chk(done_seen == 1, tag, "done seen", done_seen, 1);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
        chk(exp_q.size() == 0, tag, "queue drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: on the done pulse the memory image is final; compare it.
    always @(negedge clk) begin
        if (!rst && done) begin
            for (int i = 0; i < 64; i++) begin
                logic [7:0] e;
                if (exp_q.size() == 0) e = 8'hXX; else e = exp_q.pop_front();
                chk(mem[i] === e, cur_tag, $sformatf("byte 0x%0h", i), int'(mem[i]), int'(e));
            end
            done_seen = 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_mem(8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11", "reset done", int'(done), 0);
        chk(ram_we == 1'b0, "R1", "reset we", int'(ram_we), 0);

        // R1: no start code, memory untouched
        clear_mem(8'h00); mem[0] = 8'h01; mem[1] = 8'h03; mem[63] = 8'h00;
        run_case("R1");
        clear_mem(8'h00); mem[0] = 8'h01; mem[1] = 8'h03; mem[63] = 8'h02;
        run_case("R1");

        // R7 / R4: status on channel 0, zeros for 1..3, status on channel 4
        clear_mem(8'h00);
        mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h00;
        mem[6] = 8'h00; mem[7] = 8'h00; mem[8] = 8'h00;
        mem[9] = 8'h01; mem[10] = 8'h03; mem[11] = 8'hFF; mem[15] = 8'hFE;
        mem[63] = 8'h01;
        run_case("R7");

        // R8: buttons on channel 0
        clear_mem(8'hEE);
        mem[0] = 8'h01; mem[1] = 8'h04; mem[2] = 8'h01; mem[7] = 8'hFE; mem[63] = 8'h01;
        run_case("R8");

        // R6 / R3: negative skip then status on channel 1 fails; unknown code fails
        clear_mem(8'h00);
        mem[0] = 8'hFF; mem[1] = 8'h01; mem[2] = 8'h03; mem[3] = 8'h00;
        mem[4] = 8'h01; mem[5] = 8'h04; mem[6] = 8'h01;
        mem[7] = 8'hFE; mem[63] = 8'h01;
        run_case("R6");
        clear_mem(8'h00);
        mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h07; mem[3] = 8'hFE; mem[63] = 8'h01;
        run_case("R8");

        // R4: channel 5 fails every command
        clear_mem(8'h00);
        mem[5] = 8'h01; mem[6] = 8'h03; mem[7] = 8'h00; mem[8] = 8'hFE; mem[63] = 8'h01;
        run_case("R4");

        // R5 / R2: receive 0xFE and transmit 0xFE end the walk
        clear_mem(8'h55);
        mem[0] = 8'h01; mem[1] = 8'hFE; mem[2] = 8'h00; mem[63] = 8'h01;
        run_case("R5");
        clear_mem(8'h00); mem[0] = 8'hFE; mem[1] = 8'h01; mem[2] = 8'h03; mem[63] = 8'h01;
        run_case("R2");

        // R3: 0x41 skipped, then status on channel 1 fails
        clear_mem(8'h00);
        mem[0] = 8'h41; mem[1] = 8'h01; mem[2] = 8'h03; mem[3] = 8'h00;
        mem[7] = 8'hFE; mem[63] = 8'h01;
        run_case("R3");

        // R9: longer receive pads zeros, shorter truncates
        clear_mem(8'h33);
        mem[0] = 8'h01; mem[1] = 8'h06; mem[2] = 8'h00; mem[9] = 8'hFE; mem[63] = 8'h01;
        run_case("R9");
        clear_mem(8'h33);
        mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h01; mem[5] = 8'hFE; mem[63] = 8'h01;
        run_case("R9");

        // R10: receive area crosses the end; frame needing byte 0x3F
        clear_mem(8'h77);
        mem[0] = 8'h37; mem[1] = 8'h08; mem[2] = 8'h00; mem[63] = 8'h01;
        run_case("R10");
        clear_mem(8'h00); mem[62] = 8'h01; mem[63] = 8'h01;
        run_case("R10");

        // R2: all zero lengths walk to the end
        clear_mem(8'h00); mem[63] = 8'h01;
        run_case("R2");

        // R5 / R11: pseudo-random frame streams
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 63; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (lfsr[2:0])
                    3'd7:    mem[i] = 8'hFF;
                    3'd6:    mem[i] = 8'h41;
                    default: mem[i] = {5'd0, lfsr[5:3]};
                endcase
            end
            mem[63] = 8'h01;
            pad_word = {lfsr, ~lfsr};
            run_case("R5");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule